// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block holds a free-running counter and a compare register, both 32 bits wide by default, and flags a timer interrupt when the two are equal. Software can write either register through its own strobe and data bus. Both registers are always visible on read-data outputs. The counter advances once every `TICK_DIV` clock cycles. When it passes its largest value it wraps to zero and keeps running.

The pending output drives the timer bit of a cause register. Once set, it stays set until software writes the compare register. The count moving past the match value does not clear it. The flag is only a level. A later interrupt stage that is enabled takes it on its next cycle. Masking, priority and exception entry are handled outside this block.

Top module: `cc_timer`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, the count reads 0, the compare reads all ones and the pending output is 0.
- R2: With no count write, the count increases by one on every `TICK_DIV`-th rising edge after reset is released (the 2nd, 4th, 6th edge for the default of 2), and holds its value on all other edges.
- R3: An increment from all ones gives zero, and counting continues from there.
- R4: If the count register equals the compare register in a cycle with no compare write, the pending output is 1 from the next cycle onward.
- R5: Once the pending output is 1, it stays 1 while no compare write occurs, even after the count has moved past the compare value.
- R6: A compare write loads the written value into the compare register and sets the pending output to 0 on the following cycle.
- R7: A count write loads its data into the count register on that edge, even when an increment falls due on the same edge.
- R8: A count/compare match in the same cycle as a compare write does not set the pending output.
- R9: The count and compare read outputs always show the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | CNT_W | Count write data |
| cmp_we | input | 1 | Compare write strobe |
| cmp_wdata | input | CNT_W | Compare write data |
| cnt_rdata | output | CNT_W | Current count |
| cmp_rdata | output | CNT_W | Current compare value |
| timer_pend | output | 1 | Sticky timer-interrupt pending flag |

## Verification
The bench targets several corner cases:
- **Wrap from all ones.** A counter that saturates or carries wrongly would stall at all ones or jump to a wrong value.
- **Count write on an increment edge.** If the increment won, the count would read one more than the written value.
- **Match on the same cycle as a compare write.** If the match won, the flag would be set straight after it was cleared.
- **Count moving past the match.** A flag built from plain equality would drop as soon as the counter moved on.

Random writes placed near the running count create frequent matches. These show up any error in the divide phase or in the one-cycle delay of the pending flag.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  localparam int unsigned CC_WIDTH_DEF = 32;
  localparam int unsigned CC_DIV_DEF   = 2;

  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_INC   = 2'd1,
    CNT_LOAD  = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/cc_tick_gen.sv
module cc_tick_gen #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      logic [PW-1:0] phase;
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);

      always_ff @(posedge clk) begin
        if (rst)                phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
      end

      assign tick = (phase == LAST);

      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/cc_count_reg.sv
module cc_count_reg
  import cc_timer_pkg::*;
#(
  parameter int unsigned W = CC_WIDTH_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count
);
  cnt_op_e op;

  always_comb begin
    if (we)        op = CNT_LOAD;
    else if (tick) op = CNT_INC;
    else           op = CNT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      case (op)
        CNT_LOAD: count <= wdata;
        CNT_INC:  count <= count + W'(1);
        default:  count <= count;
      endcase
    end
  end

  // R7
  cnt_load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> count == $past(wdata));
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !we) |=> count == W'($past(count) + W'(1)));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !we) |=> $stable(count));
endmodule

// File: rtl/cc_match_pend.sv
module cc_match_pend
  import cc_timer_pkg::*;
#(
  parameter int unsigned W = CC_WIDTH_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] count,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] compare,
  output logic         pend
);
  logic hit;
  assign hit = (count == compare);

  always_ff @(posedge clk) begin
    if (rst)     compare <= '1;
    else if (we) compare <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)      pend <= 1'b0;
    else if (we)  pend <= 1'b0;
    else if (hit) pend <= 1'b1;
  end

  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> !pend);
  // R5
  pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && !we) |=> pend);
  // R4
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((count == compare) && !we) |=> pend);
  // R6
  cmp_load_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> compare == $past(wdata));
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int unsigned CNT_W    = CC_WIDTH_DEF,
  parameter int unsigned TICK_DIV = CC_DIV_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] cnt_rdata,
  output logic [CNT_W-1:0] cmp_rdata,
  output logic             timer_pend
);
  logic             tick;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] compare_q;
  logic             pend_q;

  cc_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  cc_count_reg #(.W(CNT_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .we    (cnt_we),
    .wdata (cnt_wdata),
    .count (count_q)
  );

  cc_match_pend #(.W(CNT_W)) u_match (
    .clk     (clk),
    .rst     (rst),
    .count   (count_q),
    .we      (cmp_we),
    .wdata   (cmp_wdata),
    .compare (compare_q),
    .pend    (pend_q)
  );

  assign cnt_rdata  = count_q;
  assign cmp_rdata  = compare_q;
  assign timer_pend = pend_q;

  // R8
  same_cycle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_we && (cnt_rdata == cmp_rdata)) |=> !timer_pend);
endmodule

// File: tb/cc_timer_tb.sv
module cc_timer_tb;
  localparam int unsigned W   = 32;
  localparam int unsigned DIV = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnt_we = 1'b0, cmp_we = 1'b0;
  logic [W-1:0] cnt_wdata = '0, cmp_wdata = '0;
  logic [W-1:0] cnt_rdata, cmp_rdata;
  logic         timer_pend;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  cc_timer #(.CNT_W(W), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .cnt_rdata(cnt_rdata), .cmp_rdata(cmp_rdata),
    .timer_pend(timer_pend)
  );

  // expected state derived from the requirements
  int           m_edges;
  logic [W-1:0] m_cnt, m_cmp;
  logic         m_pend;

  function automatic bit due_tick(int edge_no);
    return (edge_no % DIV) == 0;
  endfunction

  function automatic logic [W-1:0] next_cnt(logic [W-1:0] c, bit we,
                                            logic [W-1:0] d, bit tk);
    if (we) return d;
    if (tk) return c + W'(1);
    return c;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_edges <= 0;
      m_cnt   <= '0;
      m_cmp   <= '1;
      m_pend  <= 1'b0;
    end else begin
      m_edges <= m_edges + 1;
      m_cnt   <= next_cnt(m_cnt, cnt_we, cnt_wdata, due_tick(m_edges + 1));
      if (cmp_we) m_cmp <= cmp_wdata;
      m_pend  <= cmp_we ? 1'b0 : ((m_cnt == m_cmp) ? 1'b1 : m_pend);
    end
  end

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison against the expected state
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 count", cnt_rdata, m_cnt);
      check("R9 compare", cmp_rdata, m_cmp);
      check("R4 pending", {31'b0, timer_pend}, {31'b0, m_pend});
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt_we = 1'b0; cmp_we = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while held
    check("R1 count", cnt_rdata, '0);
    check("R1 compare", cmp_rdata, '1);
    check("R1 pending", {31'b0, timer_pend}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 count after release", cnt_rdata, '0);
    @(negedge clk);
    check("R2 first increment", cnt_rdata, 32'd1);

    // R3 wrap
    cnt_we = 1'b1; cnt_wdata = '1;
    @(negedge clk); cnt_we = 1'b0;
    for (int i = 0; i < 4 && cnt_rdata == '1; i++) @(negedge clk);
    check("R3 wrap", cnt_rdata, '0);

    // R7 write on both phases; last written value must stand
    cnt_we = 1'b1; cnt_wdata = 32'h100;
    @(negedge clk);
    @(negedge clk);
    check("R7 write wins", cnt_rdata, 32'h100);
    cnt_we = 1'b0;

    // R4 match then R5 sticky
    cmp_we = 1'b1; cmp_wdata = 32'h200;
    cnt_we = 1'b1; cnt_wdata = 32'h1FF;
    @(negedge clk); cmp_we = 1'b0; cnt_we = 1'b0;
    for (int i = 0; i < 6 && !timer_pend; i++) @(negedge clk);
    check("R4 match sets", {31'b0, timer_pend}, 32'd1);
    idle(10);
    check("R5 sticky", {31'b0, timer_pend}, 32'd1);

    // R6 compare write clears
    cmp_we = 1'b1; cmp_wdata = 32'hFFFF;
    @(negedge clk); cmp_we = 1'b0;
    check("R6 clear", {31'b0, timer_pend}, '0);
    check("R6 compare loaded", cmp_rdata, 32'hFFFF);

    // R8 match coincides with compare write
    cmp_we = 1'b1; cmp_wdata = 32'h300; cnt_we = 1'b1; cnt_wdata = 32'h300;
    @(negedge clk);
    @(negedge clk);
    check("R8 write beats match", {31'b0, timer_pend}, '0);
    cmp_we = 1'b0; cnt_we = 1'b0;
    @(negedge clk);
    check("R4 match after write", {31'b0, timer_pend}, 32'd1);

    // random phase: writes placed near the running count
    void'($urandom(32'h5EED_C0DE));
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cnt_we    = ($urandom % 16) == 0;
      cnt_wdata = (($urandom % 4) == 0) ? (32'hFFFF_FFF0 + ($urandom % 16)) : $urandom;
      cmp_we    = ($urandom % 12) == 0;
      cmp_wdata = m_cnt + ($urandom % 8);
    end
    idle(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule